// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block connects two 18-bit buses, side A and side B, and moves data between them in either direction without inverting it. Each direction has a storage path with its own four controls: an active-low drive enable, an active-high pass-through enable, a capture clock, and an active-low clock gate. The storage path can be transparent, so the far side follows the near side combinationally. It can capture on the rising clock edge. It can also hold the stored word while the near-side input keeps changing.

The storage state does not depend on the drive enable. A word can be captured while a side is released and presented later. The core produces a plain data word and a drive-enable bit per direction. A thin wrapper at the top turns these into tri-state pins. An active-low reset clears both stored words so that simulation and silicon start from a known value.

Top module: `ubt_transceiver`

## Requirements
- R1: The data path is 18 bits wide and non-inverting: with a direction transparent and driving, every bit of the far side equals the same bit of the near side.
- R2: While a direction's active-low drive enable is high, that direction leaves its far side undriven, so another driver sets the bus value. While it is low, the far side is driven.
- R3: While a direction's pass-through enable is high, its far side follows the near side, whatever that direction's clock and clock gate do.
- R4: With pass-through low and clock gate low, a rising edge of that direction's clock captures the near-side word, and the far side shows it from then on.
- R5: With pass-through low and the clock steady, changes on the near side do not reach the far side.
- R6: With the clock gate high, rising clock edges do not change the stored word.
- R7: The B-to-A direction behaves as in R1 to R6 with its own four controls. Activity on the A-to-B controls does not change what B-to-A presents.
- R8: When pass-through falls, the word present just before the fall is held.
- R9: Capture works while the drive enable is high. The captured word appears once the drive enable goes low.
- R10: While the active-low reset is low, both stored words are zero and clock edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, clears both stored words |
| oe_ab_n | input | 1 | A-to-B drive enable, active low |
| le_ab | input | 1 | A-to-B pass-through enable, active high |
| cp_ab | input | 1 | A-to-B capture clock, rising edge |
| ce_ab_n | input | 1 | A-to-B clock gate, active low |
| oe_ba_n | input | 1 | B-to-A drive enable, active low |
| le_ba | input | 1 | B-to-A pass-through enable, active high |
| cp_ba | input | 1 | B-to-A capture clock, rising edge |
| ce_ba_n | input | 1 | B-to-A clock gate, active low |
| port_a | inout | 18 | Side A bus |
| port_b | inout | 18 | Side B bus |

## Verification
On every clock edge of each direction, the assertions check four things: an enabled edge captures the near-side word, a gated edge leaves the clocked register alone, the pass-through element takes priority while it is open, and the held word tracks the input during pass-through. The bench scenarios cover the rest, because it happens between clock edges or only at the pins. This includes the release of a side while the other driver sets the bus, the hold after pass-through falls, the combinational follow while the clock toggles, the independence of the two directions, and the reset value seen through the drivers.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int unsigned DEF_WIDTH = 18;
  localparam int unsigned NDIR      = 2;

  typedef enum logic [0:0] {
    DIR_AB = 1'b0,
    DIR_BA = 1'b1
  } ubt_dir_e;

  // The clocked register holds the newer word when the two toggles differ.
  function automatic logic flop_is_newer(input logic tog_flop, input logic tog_latch);
    return tog_flop != tog_latch;
  endfunction

  // Toggle value the clocked register takes on a load, so that it becomes the newer one.
  function automatic logic claim_toggle(input logic tog_latch);
    return ~tog_latch;
  endfunction
endpackage

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int unsigned WIDTH = ubt_pkg::DEF_WIDTH
) (
  input  logic             rst_n,
  input  logic             le,
  input  logic             cp,
  input  logic             ce_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] held
);
  logic [WIDTH-1:0] flop_q;
  logic [WIDTH-1:0] lat_q;
  logic             tog_f;
  logic             tog_l;
  logic             flop_newest;
  logic             edge_load;

  assign edge_load = ~ce_n;

  // Edge-capture element: loads on a rising edge when the clock gate is open.
  always_ff @(posedge cp or negedge rst_n) begin
    if (!rst_n) begin
      flop_q <= '0;
      tog_f  <= 1'b0;
    end else if (edge_load) begin
      flop_q <= din;
      tog_f  <= ubt_pkg::claim_toggle(tog_l);
    end
  end

  // Pass-through element: follows the input while le is high, then keeps the last word.
  always_latch begin
    if (!rst_n) begin
      lat_q = '0;
      tog_l = 1'b0;
    end else if (le) begin
      lat_q = din;
      tog_l = tog_f;
    end
  end

  assign flop_newest = ubt_pkg::flop_is_newer(tog_f, tog_l);
  assign held        = flop_newest ? flop_q : lat_q;

  p_edge_capture_r4: assert property (@(posedge cp) disable iff (!rst_n)
    (!ce_n && !le) |=> (flop_q == $past(din)))
    else $error("R4 edge capture lost");

  p_ce_hold_r6: assert property (@(posedge cp) disable iff (!rst_n)
    ce_n |=> $stable(flop_q))
    else $error("R6 gated edge changed storage");

  p_latch_priority_r3: assert property (@(posedge cp) disable iff (!rst_n)
    le |-> !flop_newest)
    else $error("R3 pass-through element not selected");

  p_latch_track_r8: assert property (@(posedge cp) disable iff (!rst_n)
    le |-> (held == din))
    else $error("R8 held word not tracking input");
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
  parameter int unsigned WIDTH = ubt_pkg::DEF_WIDTH
) (
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             le,
  input  logic             cp,
  input  logic             ce_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drv_en
);
  logic [WIDTH-1:0] held;

  ubt_store #(.WIDTH(WIDTH)) u_store (
    .rst_n (rst_n),
    .le    (le),
    .cp    (cp),
    .ce_n  (ce_n),
    .din   (din),
    .held  (held)
  );

  // Pass-through bypasses the storage so the far side follows combinationally.
  assign dout   = le ? din : held;
  assign drv_en = ~oe_n;
endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver #(
  parameter int unsigned WIDTH = ubt_pkg::DEF_WIDTH
) (
  input  logic             rst_n,
  input  logic             oe_ab_n,
  input  logic             le_ab,
  input  logic             cp_ab,
  input  logic             ce_ab_n,
  input  logic             oe_ba_n,
  input  logic             le_ba,
  input  logic             cp_ba,
  input  logic             ce_ba_n,
  inout  wire  [WIDTH-1:0] port_a,
  inout  wire  [WIDTH-1:0] port_b
);
  import ubt_pkg::*;

  logic [NDIR-1:0]  oe_v;
  logic [NDIR-1:0]  le_v;
  logic [NDIR-1:0]  cp_v;
  logic [NDIR-1:0]  ce_v;
  logic [NDIR-1:0]  drv_v;
  logic [WIDTH-1:0] din_v  [NDIR];
  logic [WIDTH-1:0] dout_v [NDIR];

  assign oe_v[DIR_AB] = oe_ab_n;
  assign oe_v[DIR_BA] = oe_ba_n;
  assign le_v[DIR_AB] = le_ab;
  assign le_v[DIR_BA] = le_ba;
  assign cp_v[DIR_AB] = cp_ab;
  assign cp_v[DIR_BA] = cp_ba;
  assign ce_v[DIR_AB] = ce_ab_n;
  assign ce_v[DIR_BA] = ce_ba_n;
  assign din_v[DIR_AB] = port_a;
  assign din_v[DIR_BA] = port_b;

  for (genvar g = 0; g < NDIR; g++) begin : g_lane
    ubt_lane #(.WIDTH(WIDTH)) u_lane (
      .rst_n  (rst_n),
      .oe_n   (oe_v[g]),
      .le     (le_v[g]),
      .cp     (cp_v[g]),
      .ce_n   (ce_v[g]),
      .din    (din_v[g]),
      .dout   (dout_v[g]),
      .drv_en (drv_v[g])
    );
  end

  // Tri-state pin wrapper: each lane drives the opposite side.
  assign port_b = drv_v[DIR_AB] ? dout_v[DIR_AB] : {WIDTH{1'bz}};
  assign port_a = drv_v[DIR_BA] ? dout_v[DIR_BA] : {WIDTH{1'bz}};
endmodule

// File: tb/tb_ubt_transceiver.sv
module tb_ubt_transceiver;
  localparam int W = 18;
  // Each entry: {op[1:0], data[17:0], expected[17:0]}
  // op 0 pass-through, 1 hold then change input, 2 enabled edge, 3 gated edge
  localparam int NVEC = 8;
  localparam logic [37:0] VEC [NVEC] = '{
    {2'd0, 18'h2A5A5, 18'h2A5A5},
    {2'd1, 18'h15A5A, 18'h2A5A5},
    {2'd2, 18'h15A5A, 18'h15A5A},
    {2'd3, 18'h3FFFF, 18'h15A5A},
    {2'd1, 18'h00000, 18'h15A5A},
    {2'd2, 18'h3C0F0, 18'h3C0F0},
    {2'd0, 18'h00001, 18'h00001},
    {2'd2, 18'h20000, 18'h20000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_ab_n = 1'b1, le_ab = 1'b0, cp_ab = 1'b0, ce_ab_n = 1'b0;
  logic oe_ba_n = 1'b1, le_ba = 1'b0, cp_ba = 1'b0, ce_ba_n = 1'b0;
  logic a_en = 1'b0, b_en = 1'b0;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  wire  [W-1:0] port_a, port_b;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign port_a = a_en ? a_drv : {W{1'bz}};
  assign port_b = b_en ? b_drv : {W{1'bz}};

  ubt_transceiver dut (
    .rst_n(rst_n), .oe_ab_n(oe_ab_n), .le_ab(le_ab), .cp_ab(cp_ab), .ce_ab_n(ce_ab_n),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .cp_ba(cp_ba), .ce_ba_n(ce_ba_n),
    .port_a(port_a), .port_b(port_b)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Bench discipline: only one side may be driven at a time.
  task automatic chk_one_driver(input string tag);
    total++;
    if ((a_en && !oe_ba_n) || (b_en && !oe_ab_n)) begin
      bad++;
      $display("FAIL %s one-driver actual=contention expected=single", tag);
    end
  endtask

  task automatic set_le(input bit dir, input logic v);
    if (dir) le_ba = v; else le_ab = v;
  endtask
  task automatic set_ce(input bit dir, input logic v);
    if (dir) ce_ba_n = v; else ce_ab_n = v;
  endtask
  task automatic set_cp(input bit dir, input logic v);
    if (dir) cp_ba = v; else cp_ab = v;
  endtask
  task automatic drive_in(input bit dir, input logic [W-1:0] d);
    if (dir) b_drv = d; else a_drv = d;
  endtask
  function automatic logic [W-1:0] far_side(input bit dir);
    return dir ? port_a : port_b;
  endfunction

  task automatic pulse(input bit dir);
    set_cp(dir, 1'b1); tick(1);
    set_cp(dir, 1'b0); tick(1);
  endtask

  task automatic step(input bit dir, input logic [1:0] op, input logic [W-1:0] d);
    case (op)
      2'd0: begin set_ce(dir, 1'b1); set_le(dir, 1'b1); drive_in(dir, d); tick(2); set_ce(dir, 1'b0); end
      2'd1: begin set_le(dir, 1'b0); tick(1); drive_in(dir, d); tick(2); end
      2'd2: begin set_le(dir, 1'b0); set_ce(dir, 1'b0); drive_in(dir, d); tick(1); pulse(dir); end
      default: begin
        set_le(dir, 1'b0); set_ce(dir, 1'b1); drive_in(dir, d); tick(1);
        pulse(dir); set_ce(dir, 1'b0); tick(1);
      end
    endcase
  endtask

  task automatic walk_table(input bit dir);
    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] op;
      op = VEC[k][37:36];
      step(dir, op, VEC[k][35:18]);
      case (op)
        2'd0: chk(dir ? "R7 R1 R3 pass-through" : "R1 R3 pass-through", far_side(dir), VEC[k][17:0]);
        2'd1: chk(dir ? "R7 R5 R8 hold" : "R5 R8 hold", far_side(dir), VEC[k][17:0]);
        2'd2: chk(dir ? "R7 R4 capture" : "R4 capture", far_side(dir), VEC[k][17:0]);
        default: chk(dir ? "R7 R6 gated edge" : "R6 gated edge", far_side(dir), VEC[k][17:0]);
      endcase
    end
  endtask

  initial begin
    // R10: reset clears storage and ignores clock edges
    oe_ab_n = 1'b0; a_en = 1'b1; a_drv = 18'h3FFFF;
    tick(2); pulse(1'b0); tick(1);
    chk("R10 reset A-to-B", port_b, 18'h00000);
    oe_ab_n = 1'b1; a_en = 1'b0; tick(1);
    oe_ba_n = 1'b0; b_en = 1'b1; b_drv = 18'h3FFFF;
    tick(2); pulse(1'b1); tick(1);
    chk("R10 reset B-to-A", port_a, 18'h00000);
    oe_ba_n = 1'b1; b_en = 1'b0; tick(1);
    rst_n = 1'b1; tick(2);

    // A-to-B table walk
    oe_ab_n = 1'b0; a_en = 1'b1; tick(1);
    chk_one_driver("R2 A-to-B setup");
    walk_table(1'b0);

    // R3: pass-through ignores clock and gate activity
    le_ab = 1'b1; ce_ab_n = 1'b0; a_drv = 18'h0F0F0; tick(1);
    cp_ab = 1'b1; tick(1); a_drv = 18'h30303; tick(1);
    chk("R3 follow with clock high", port_b, 18'h30303);
    cp_ab = 1'b0; tick(1);
    chk("R3 follow after clock low", port_b, 18'h30303);
    le_ab = 1'b0; tick(1); a_drv = 18'h00000; tick(2);
    chk("R8 held after pass-through fall", port_b, 18'h30303);

    // R2 and R9: released side, capture while released
    oe_ab_n = 1'b1; tick(1); b_en = 1'b1; b_drv = 18'h00000; tick(2);
    chk("R2 side B released", port_b, 18'h00000);
    chk_one_driver("R2 released");
    a_drv = 18'h12345; tick(1); pulse(1'b0);
    b_en = 1'b0; tick(1); oe_ab_n = 1'b0; tick(2);
    chk("R9 captured while released", port_b, 18'h12345);

    // B-to-A table walk
    oe_ab_n = 1'b1; a_en = 1'b0; tick(1);
    oe_ba_n = 1'b0; b_en = 1'b1; b_drv = 18'h00000; tick(1);
    le_ba = 1'b0; tick(1);
    chk_one_driver("R7 B-to-A setup");
    walk_table(1'b1);

    // R7: A-to-B controls do not disturb B-to-A
    le_ab = 1'b1; tick(1); cp_ab = 1'b1; tick(1); cp_ab = 1'b0; le_ab = 1'b0;
    ce_ab_n = 1'b1; tick(1); cp_ab = 1'b1; tick(1); cp_ab = 1'b0; ce_ab_n = 1'b0; tick(2);
    chk("R7 independent of A-to-B controls", port_a, 18'h20000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule